// File: doc/BRIEF.md
# Aligned Burst Splitter

This block takes a request to move one buffer, given as a start address and a byte count, and turns it into a sequence of bus transactions. It steps through the buffer in chunks of one burst length. The last chunk carries whatever bytes are left. A chunk that would straddle a burst-aligned boundary is not rejected. It is issued as two transactions, cut exactly at that boundary, so no transaction ever crosses one.

Transactions are offered one at a time on a valid/acknowledge pair. The address, byte length and byte enables are held steady until the acknowledge arrives. The following transaction is presented in the next cycle. After the final acknowledge, a one-cycle done pulse marks the end of the buffer. The data path can be 32 or 64 bits wide. On a 64-bit path, the first-beat and last-beat byte enables mark the valid half-word when a transaction starts or ends on an address that is 4 modulo 8. Moving the data itself and handling descriptors are left to the surrounding logic.

Top module: `bsplit_top`

## Requirements
- R1: After reset, txn_valid and done are low.
- R2: A start pulse with a nonzero size, taken while idle, presents the first transaction in the next cycle, at the start address.
- R3: Transactions cover the buffer contiguously. Each one begins where the previous one ended, and the buffer is walked in chunks of BURST_BYTES. The last chunk is the remainder when fewer than BURST_BYTES bytes are left.
- R4: A chunk whose start offset within a burst (address mod BURST_BYTES) plus its length exceeds BURST_BYTES is issued as two transactions. The first carries BURST_BYTES minus the offset. The second carries the rest of the chunk.
- R5: Every transaction length lies in 1..BURST_BYTES, and no transaction crosses a BURST_BYTES-aligned boundary.
- R6: While txn_valid is high and txn_ack is low, the address, length and byte enables hold steady. The next transaction appears in the cycle after the acknowledge.
- R7: done is high for exactly one cycle, in the cycle after the final acknowledge, and txn_valid is low in that cycle.
- R8: A start pulse with size zero raises done in the next cycle and issues no transaction.
- R9: With DATA_W=64, lane i enables byte i. txn_first_be is 8'hF0 when the address is 4 mod 8, and 8'hFF otherwise. txn_last_be is 8'h0F when address plus length is 4 mod 8, and 8'hFF otherwise. With DATA_W=32, both enables are 4'hF.
- R10: A start pulse that arrives while a buffer is in progress is ignored, and the transaction on offer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a buffer |
| start_addr | input | ADDR_W | Buffer base address, a multiple of 4 |
| start_size | input | SIZE_W | Buffer size in bytes, a multiple of 4 |
| txn_ack | input | 1 | Acknowledges the transaction on offer |
| txn_valid | output | 1 | A transaction is on offer |
| txn_addr | output | ADDR_W | Transaction byte address |
| txn_len | output | LEN_W | Transaction length in bytes |
| txn_first_be | output | DATA_W/8 | Byte enables of the first beat |
| txn_last_be | output | DATA_W/8 | Byte enables of the last beat |
| done | output | 1 | One-cycle pulse when the buffer is finished |

## Verification
Every result is registered. The first transaction is visible one cycle after the edge that samples start, and each following transaction or the done pulse is visible one cycle after the edge that samples the acknowledge. A zero-size start shows done one cycle after the start edge. The bench drives inputs and reads outputs only on falling clock edges. Each result is therefore read half a cycle after the rising edge that produces it, and any acknowledge delay is counted in whole cycles before the next read.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bsplit_state_t;
endpackage

// File: rtl/bsplit_plan.sv
module bsplit_plan #(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 16,
  parameter int LEN_W       = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  chunk,
  output logic [LEN_W-1:0]  len
);
  localparam int OFF_W = $clog2(BURST_BYTES);

  logic [LEN_W-1:0] offset;
  logic [LEN_W-1:0] room;

  always_comb begin
    offset = LEN_W'(addr[OFF_W-1:0]);
    room   = LEN_W'(BURST_BYTES) - offset;
    len    = (chunk < room) ? chunk : room;
  end
endmodule

// File: rtl/bsplit_lanes.sv
module bsplit_lanes #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LEN_W-1:0]    len,
  output logic [DATA_W/8-1:0] first_be,
  output logic [DATA_W/8-1:0] last_be
);
  localparam int BE_W = DATA_W / 8;

  generate
    if (DATA_W == 64) begin : g_wide
      logic [2:0] end_low;
      always_comb begin
        end_low  = addr[2:0] + len[2:0];
        first_be = {4'hF, {4{~addr[2]}}};
        last_be  = {{4{~end_low[2]}}, 4'hF};
      end
    end else begin : g_narrow
      always_comb begin
        first_be = {BE_W{1'b1}};
        last_be  = {BE_W{1'b1}};
      end
    end
  endgenerate
endmodule

// File: rtl/bsplit_top.sv
module bsplit_top #(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 16,
  parameter int BURST_BYTES = 16,
  parameter int DATA_W      = 64,
  localparam int LEN_W      = $clog2(BURST_BYTES) + 1,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [SIZE_W-1:0] start_size,
  input  logic              txn_ack,
  output logic              txn_valid,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [LEN_W-1:0]  txn_len,
  output logic [BE_W-1:0]   txn_first_be,
  output logic [BE_W-1:0]   txn_last_be,
  output logic              done
);
  import bsplit_pkg::*;

  localparam int OFF_W = $clog2(BURST_BYTES);

  bsplit_state_t    state_q;
  logic [SIZE_W-1:0] rem_q;
  logic [LEN_W-1:0]  chunk_q;

  logic              load;
  logic              step;
  logic [SIZE_W-1:0] rem_after;
  logic [LEN_W-1:0]  chunk_after;
  logic [ADDR_W-1:0] n_addr;
  logic [SIZE_W-1:0] n_rem;
  logic [LEN_W-1:0]  n_chunk;
  logic [LEN_W-1:0]  p_len;
  logic [BE_W-1:0]   p_fbe;
  logic [BE_W-1:0]   p_lbe;

  function automatic logic [LEN_W-1:0] cap_burst(input logic [SIZE_W-1:0] bytes);
    if (bytes >= SIZE_W'(BURST_BYTES)) return LEN_W'(BURST_BYTES);
    else return bytes[LEN_W-1:0];
  endfunction

  always_comb begin
    load        = (state_q == ST_IDLE) && start;
    step        = txn_valid && txn_ack;
    rem_after   = rem_q - SIZE_W'(txn_len);
    chunk_after = chunk_q - txn_len;
    if (load) begin
      n_addr  = start_addr;
      n_rem   = start_size;
      n_chunk = cap_burst(start_size);
    end else begin
      n_addr  = txn_addr + ADDR_W'(txn_len);
      n_rem   = rem_after;
      n_chunk = (chunk_after == '0) ? cap_burst(rem_after) : chunk_after;
    end
  end

  bsplit_plan #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES), .LEN_W(LEN_W)) u_plan (
    .addr (n_addr),
    .chunk(n_chunk),
    .len  (p_len)
  );

  bsplit_lanes #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_lanes (
    .addr    (n_addr),
    .len     (p_len),
    .first_be(p_fbe),
    .last_be (p_lbe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      rem_q        <= '0;
      chunk_q      <= '0;
      txn_valid    <= 1'b0;
      txn_addr     <= '0;
      txn_len      <= '0;
      txn_first_be <= '0;
      txn_last_be  <= '0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load && start_size == '0) begin
        done <= 1'b1;
      end else if (step && rem_after == '0) begin
        state_q   <= ST_IDLE;
        txn_valid <= 1'b0;
        done      <= 1'b1;
      end else if (load || step) begin
        state_q      <= ST_BUSY;
        txn_valid    <= 1'b1;
        rem_q        <= n_rem;
        chunk_q      <= n_chunk;
        txn_addr     <= n_addr;
        txn_len      <= p_len;
        txn_first_be <= p_fbe;
        txn_last_be  <= p_lbe;
      end
    end
  end

  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> (txn_len != '0) && (txn_len <= LEN_W'(BURST_BYTES)) &&
                  ((LEN_W'(txn_addr[OFF_W-1:0]) + txn_len) <= LEN_W'(BURST_BYTES)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_ack) |=> txn_valid && $stable(txn_addr) && $stable(txn_len)
                                && $stable(txn_first_be) && $stable(txn_last_be));

  // R3
  contig_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_ack) |=> (!txn_valid || txn_addr == $past(txn_addr + ADDR_W'(txn_len))));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !txn_valid ##1 !done);

  // R8
  zero_size_chk: assert property (@(posedge clk) disable iff (rst)
    (!txn_valid && start && start_size == '0) |=> done && !txn_valid);

  // R9
  be_live_chk: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> (txn_first_be != '0) && (txn_last_be != '0));
endmodule

// File: tb/sim_bsplit_top.sv
module sim_bsplit_top;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int BB = 16;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic [SW-1:0] s_size = '0;
  logic          ack = 1'b0;
  logic          v0, v1, d0, d1;
  logic [AW-1:0] a0, a1;
  logic [LW-1:0] l0, l1;
  logic [7:0]    fb0, lb0;
  logic [3:0]    fb1, lb1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bsplit_top #(.ADDR_W(AW), .SIZE_W(SW), .BURST_BYTES(BB), .DATA_W(64)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(s_addr), .start_size(s_size),
    .txn_ack(ack), .txn_valid(v0), .txn_addr(a0), .txn_len(l0),
    .txn_first_be(fb0), .txn_last_be(lb0), .done(d0));

  bsplit_top #(.ADDR_W(AW), .SIZE_W(SW), .BURST_BYTES(BB), .DATA_W(32)) u1 (
    .clk(clk), .rst(rst), .start(start), .start_addr(s_addr), .start_size(s_size),
    .txn_ack(ack), .txn_valid(v1), .txn_addr(a1), .txn_len(l1),
    .txn_first_be(fb1), .txn_last_be(lb1), .done(d1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int sz);
    int rem, chunk, cur, len, dly, k;
    @(negedge clk);
    start = 1'b1; s_addr = AW'(a); s_size = SW'(sz);
    @(negedge clk);
    start = 1'b0;
    if (sz == 0) begin
      check("R8 done", 32'(d0), 1);
      check("R8 no txn", 32'(v0), 0);
      @(negedge clk);
      check("R7 done one cycle", 32'(d0), 0);
      return;
    end
    rem = sz; cur = a; chunk = 0; k = 0;
    while (rem > 0) begin
      if (chunk == 0) chunk = (rem < BB) ? rem : BB;
      len = (chunk < BB - (cur % BB)) ? chunk : BB - (cur % BB);
      check("R6 valid", 32'(v0), 1);
      check(k == 0 ? "R2 first addr" : "R3 addr", a0, 32'(cur));
      check("R4 len", 32'(l0), 32'(len));
      check("R9 first_be", 32'(fb0), (cur % 8 == 4) ? 32'hF0 : 32'hFF);
      check("R9 last_be", 32'(lb0), ((cur + len) % 8 == 4) ? 32'h0F : 32'hFF);
      check("R9 narrow be", {fb1, lb1}, 32'hFF);
      if (k == 0) begin
        start = 1'b1; s_addr = 32'h0; s_size = 16'd0;
        @(negedge clk);
        start = 1'b0;
        check("R10 addr kept", a0, 32'(cur));
        check("R10 len kept", 32'(l0), 32'(len));
        check("R10 no done", 32'(d0), 0);
      end
      dly = (cur / 4 + k) % 3;
      repeat (dly) @(negedge clk);
      check("R6 hold addr", a0, 32'(cur));
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      cur += len; rem -= len; chunk -= len; k++;
    end
    check("R7 done", 32'(d0), 1);
    check("R7 valid low", 32'(v0), 0);
    @(negedge clk);
    check("R7 done one cycle", 32'(d0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(v0), 0);
    check("R1 done", 32'(d0), 0);
    rst = 1'b0;
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s <= 64; s += 4) begin
        run(32'h100 + o * 4, s);
      end
    end
    run(32'h20C, 4);
    run(32'h3F4, 200);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule